// File: doc/BRIEF.md
# Twin-Predicated Vector Element Sequencer

This block walks the elements of a single vector operation and emits, once per clock, the pair of element numbers the datapath should use: one index into the source vector and one into the destination vector. Each side has its own predicate mask, and each index moves forward on its own. A masked-off source element is passed over, which packs the selected sources together (compress). A masked-off destination element is passed over as well, which spreads the results out (expand). With both masks active, the operation does both at once. When zeroing is enabled, masked-off destination elements are still issued, flagged for a zero write.

A start pulse captures the vector length, the masks and the mode flags. The masks can come from two 64-bit integer inputs or from the EQ bits of a run of 4-bit condition fields. Each mask can be inverted. A shared-predicate mode applies one mask to both sides. Either operand may be marked scalar. The sequencer reports completion on a level that stays high until the next start.

Top module: `twin_pred_seq`

## Requirements
- R1: A start with vector length 0 issues no pair, and `done` is high one cycle after the start edge.
- R2: `start` is sampled on a rising edge and clears `done`. The first pair appears on the following edge, and further pairs follow one per cycle. `done` rises on the edge after the last pair and stays high, with `elem_valid` low, until the next start.
- R3: The source index passes over every element whose effective source mask bit is 0. Each pair takes the next set source bit.
- R4: The destination index passes over every element whose effective destination mask bit is 0, independently of the source. Each pair takes the next set destination bit, and destination indices within a run strictly increase.
- R5: Issuing ends as soon as either side has no eligible element below the effective vector length. No issued index is ever at or above that length.
- R6: `src_inv` and `dst_inv` each invert their mask bitwise before use.
- R7: With `zero_en` set, a destination element whose mask bit is 0 is issued rather than skipped, with `write_zero` high, and the source index advances past the source element it consumed. `write_zero` is never high otherwise.
- R8: With `shared_pred` set, the destination mask (after inversion) governs both sides, and the source index always equals the destination index.
- R9: With `use_cr_pred` set, mask bit i for both sides is bit 4*(4+i)+1 of `cr_bits`, the EQ bit of condition field 4+i, where field k occupies bits 4k+3 down to 4k. The invert flags then act as a not-equal test.
- R10: With `dst_scalar` set, at most one pair is issued.
- R11: With `src_scalar` set, the source index is 0 on every pair and the source mask is not consulted.
- R12: Mask bits at or above the vector length have no effect. A vector length above 64 acts as 64.
- R13: During and right after reset, `elem_valid`, `write_zero` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new element sequence; captures all configuration |
| vl | input | 7 | Vector length |
| src_pred | input | 64 | Integer source predicate mask |
| dst_pred | input | 64 | Integer destination predicate mask |
| src_inv | input | 1 | Invert the source mask |
| dst_inv | input | 1 | Invert the destination mask |
| shared_pred | input | 1 | Destination mask governs both sides in lockstep |
| use_cr_pred | input | 1 | Take masks from condition-field EQ bits |
| cr_bits | input | 272 | Packed 4-bit condition fields |
| zero_en | input | 1 | Issue masked-off destination elements as zero writes |
| src_scalar | input | 1 | Source is a scalar (index held at 0) |
| dst_scalar | input | 1 | Destination is a scalar (single pair) |
| elem_valid | output | 1 | A pair is presented this cycle |
| src_idx | output | 6 | Source element index |
| dst_idx | output | 6 | Destination element index |
| write_zero | output | 1 | Write zero to the destination element of this pair |
| done | output | 1 | Sequence complete; held until the next start |

## Verification
The hardest condition to reach from the ports is the exact point where one side runs out first. The cases that matter are a compressed source exhausting before the destination, an expanded destination passing the length while source elements remain, and zeroing pulling the source forward across masked-off destinations. The stimulus builds small masks with a known pattern for each of these and for their inverted forms. A scoreboard is filled from a reference walk of the requirements, and each emitted pair is compared against it. An all-ones run with an oversized length drives both indices to element 63 and checks the clamp.

// File: rtl/tpseq_pkg.sv
package tpseq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;

  localparam int unsigned CR_FIELD_W = 4;
  localparam int unsigned CR_EQ_POS  = 1;
endpackage

// File: rtl/tpseq_rst_sync.sv
module tpseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/tpseq_mask_prep.sv
module tpseq_mask_prep #(
  parameter int unsigned ELEMS   = 64,
  parameter int unsigned CR_BASE = 4,
  localparam int unsigned PW     = $clog2(ELEMS) + 1,
  localparam int unsigned CRW    = tpseq_pkg::CR_FIELD_W * (CR_BASE + ELEMS)
) (
  input  logic [PW-1:0]    vl_eff,
  input  logic [ELEMS-1:0] src_pred,
  input  logic [ELEMS-1:0] dst_pred,
  input  logic [CRW-1:0]   cr_bits,
  input  logic             src_inv,
  input  logic             dst_inv,
  input  logic             use_cr,
  input  logic             shared,
  output logic [ELEMS-1:0] src_eff,
  output logic [ELEMS-1:0] dst_eff
);
  logic [ELEMS-1:0] cr_eq;
  logic [ELEMS-1:0] in_range;
  logic [ELEMS-1:0] src_raw;
  logic [ELEMS-1:0] dst_raw;
  logic [ELEMS-1:0] dst_m;
  logic             unused_cr;

  for (genvar g = 0; g < ELEMS; g++) begin : g_elem
    assign cr_eq[g]    = cr_bits[(CR_BASE + g) * tpseq_pkg::CR_FIELD_W + tpseq_pkg::CR_EQ_POS];
    assign in_range[g] = (vl_eff > PW'(g));
  end

  assign unused_cr = ^cr_bits;

  always_comb begin
    src_raw = use_cr ? cr_eq : src_pred;
    dst_raw = use_cr ? cr_eq : dst_pred;
    dst_m   = (dst_raw ^ {ELEMS{dst_inv}}) & in_range;
    dst_eff = dst_m;
    src_eff = shared ? dst_m : ((src_raw ^ {ELEMS{src_inv}}) & in_range);
  end
endmodule

// File: rtl/tpseq_scan.sv
module tpseq_scan #(
  parameter int unsigned ELEMS = 64,
  localparam int unsigned PW   = $clog2(ELEMS) + 1
) (
  input  logic [ELEMS-1:0] mask,
  input  logic [PW-1:0]    from,
  output logic             hit,
  output logic [PW-1:0]    pos
);
  always_comb begin
    hit = 1'b0;
    pos = '0;
    for (int i = ELEMS - 1; i >= 0; i--) begin
      if (mask[i] && (PW'(i) >= from)) begin
        hit = 1'b1;
        pos = PW'(i);
      end
    end
  end
endmodule

// File: rtl/twin_pred_seq.sv
module twin_pred_seq #(
  parameter int unsigned ELEMS   = 64,
  parameter int unsigned CR_BASE = 4,
  parameter int unsigned VLW     = 7,
  localparam int unsigned IW     = $clog2(ELEMS),
  localparam int unsigned PW     = IW + 1,
  localparam int unsigned CRW    = tpseq_pkg::CR_FIELD_W * (CR_BASE + ELEMS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VLW-1:0]   vl,
  input  logic [ELEMS-1:0] src_pred,
  input  logic [ELEMS-1:0] dst_pred,
  input  logic             src_inv,
  input  logic             dst_inv,
  input  logic             shared_pred,
  input  logic             use_cr_pred,
  input  logic [CRW-1:0]   cr_bits,
  input  logic             zero_en,
  input  logic             src_scalar,
  input  logic             dst_scalar,
  output logic             elem_valid,
  output logic [IW-1:0]    src_idx,
  output logic [IW-1:0]    dst_idx,
  output logic             write_zero,
  output logic             done
);
  import tpseq_pkg::*;

  logic rst_n_sync;

  tpseq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  // length clamp and mask preparation at capture time
  logic [PW-1:0]    vl_clamped;
  logic [ELEMS-1:0] src_eff, dst_eff;

  assign vl_clamped = (32'(vl) > ELEMS) ? PW'(ELEMS) : PW'(vl);

  tpseq_mask_prep #(.ELEMS(ELEMS), .CR_BASE(CR_BASE)) u_prep (
    .vl_eff   (vl_clamped),
    .src_pred (src_pred),
    .dst_pred (dst_pred),
    .cr_bits  (cr_bits),
    .src_inv  (src_inv),
    .dst_inv  (dst_inv),
    .use_cr   (use_cr_pred),
    .shared   (shared_pred),
    .src_eff  (src_eff),
    .dst_eff  (dst_eff)
  );

  // captured configuration
  logic [ELEMS-1:0] smask_q, dmask_q;
  logic [PW-1:0]    vl_q;
  logic             zero_q, sscal_q, dscal_q, shared_q;
  logic             cfg_load;

  assign cfg_load = start;

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      smask_q  <= '0;
      dmask_q  <= '0;
      vl_q     <= '0;
      zero_q   <= 1'b0;
      sscal_q  <= 1'b0;
      dscal_q  <= 1'b0;
      shared_q <= 1'b0;
    end else if (cfg_load) begin
      smask_q  <= src_eff;
      dmask_q  <= dst_eff;
      vl_q     <= vl_clamped;
      zero_q   <= zero_en;
      sscal_q  <= src_scalar;
      dscal_q  <= dst_scalar;
      shared_q <= shared_pred;
    end
  end

  // per-side search
  seq_state_e    state_q, state_n;
  logic [PW-1:0] sptr_q, sptr_n, dptr_q, dptr_n;
  logic          valid_n, wz_n, done_n;
  logic [IW-1:0] sidx_n, didx_n;

  logic          s_hit, d_hit;
  logic [PW-1:0] s_pos, d_pos;
  logic          s_ok, d_ok;
  logic [PW-1:0] s_c, d_c;

  tpseq_scan #(.ELEMS(ELEMS)) u_scan_src (
    .mask (smask_q),
    .from (sptr_q),
    .hit  (s_hit),
    .pos  (s_pos)
  );

  tpseq_scan #(.ELEMS(ELEMS)) u_scan_dst (
    .mask (dmask_q),
    .from (dptr_q),
    .hit  (d_hit),
    .pos  (d_pos)
  );

  always_comb begin
    if (zero_q) begin
      d_ok = (dptr_q < vl_q);
      d_c  = dptr_q;
    end else begin
      d_ok = d_hit;
      d_c  = d_pos;
    end

    if (sscal_q) begin
      s_ok = 1'b1;
      s_c  = '0;
    end else if (shared_q) begin
      s_ok = d_ok;
      s_c  = d_c;
    end else begin
      s_ok = s_hit;
      s_c  = s_pos;
    end
  end

  // next-state logic
  always_comb begin
    state_n = state_q;
    sptr_n  = sptr_q;
    dptr_n  = dptr_q;
    valid_n = 1'b0;
    wz_n    = 1'b0;
    done_n  = done;
    sidx_n  = src_idx;
    didx_n  = dst_idx;

    if (start) begin
      sptr_n  = '0;
      dptr_n  = '0;
      done_n  = (vl_clamped == '0);
      state_n = (vl_clamped == '0) ? SEQ_DONE : SEQ_RUN;
    end else if (state_q == SEQ_RUN) begin
      if (s_ok && d_ok) begin
        valid_n = 1'b1;
        sidx_n  = s_c[IW-1:0];
        didx_n  = d_c[IW-1:0];
        wz_n    = zero_q & ~dmask_q[d_c[IW-1:0]];
        sptr_n  = s_c + PW'(1);
        dptr_n  = dscal_q ? vl_q : (d_c + PW'(1));
      end else begin
        done_n  = 1'b1;
        state_n = SEQ_DONE;
      end
    end
  end

  // state and output registers
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      state_q    <= SEQ_IDLE;
      sptr_q     <= '0;
      dptr_q     <= '0;
      elem_valid <= 1'b0;
      write_zero <= 1'b0;
      done       <= 1'b0;
      src_idx    <= '0;
      dst_idx    <= '0;
    end else begin
      state_q    <= state_n;
      sptr_q     <= sptr_n;
      dptr_q     <= dptr_n;
      elem_valid <= valid_n;
      write_zero <= wz_n;
      done       <= done_n;
      src_idx    <= sidx_n;
      dst_idx    <= didx_n;
    end
  end
endmodule

// File: rtl/tpseq_chk.sv
module tpseq_chk #(
  parameter int unsigned ELEMS = 64,
  parameter int unsigned VLW   = 7,
  localparam int unsigned IW   = $clog2(ELEMS),
  localparam int unsigned PW   = IW + 1
) (
  input logic           clk,
  input logic           rst_n_sync,
  input logic           start,
  input logic [VLW-1:0] vl,
  input logic           zero_en,
  input logic           src_scalar,
  input logic           dst_scalar,
  input logic           elem_valid,
  input logic [IW-1:0]  src_idx,
  input logic [IW-1:0]  dst_idx,
  input logic           write_zero,
  input logic           done
);
  logic [PW-1:0] len_seen;
  logic          zero_seen, ss_seen, ds_seen;

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      len_seen  <= '0;
      zero_seen <= 1'b0;
      ss_seen   <= 1'b0;
      ds_seen   <= 1'b0;
    end else if (start) begin
      len_seen  <= (32'(vl) > ELEMS) ? PW'(ELEMS) : PW'(vl);
      zero_seen <= zero_en;
      ss_seen   <= src_scalar;
      ds_seen   <= dst_scalar;
    end
  end

  p_empty_len_r1: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (start && vl == '0) |=> (done && !elem_valid));

  p_done_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    done |-> !elem_valid);

  p_done_held_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (done && !start) |=> done);

  p_dst_rising_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (elem_valid && $past(elem_valid)) |-> (dst_idx > $past(dst_idx)));

  p_in_length_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    elem_valid |-> ((PW'(dst_idx) < len_seen) && (ss_seen || PW'(src_idx) < len_seen)));

  p_zero_only_r7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    write_zero |-> (elem_valid && zero_seen));

  p_single_r10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (elem_valid && ds_seen && !start) |=> !elem_valid);

  p_src_fixed_r11: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (elem_valid && ss_seen) |-> (src_idx == '0));
endmodule

bind twin_pred_seq tpseq_chk #(.ELEMS(ELEMS), .VLW(VLW)) u_chk (
  .clk        (clk),
  .rst_n_sync (rst_n_sync),
  .start      (start),
  .vl         (vl),
  .zero_en    (zero_en),
  .src_scalar (src_scalar),
  .dst_scalar (dst_scalar),
  .elem_valid (elem_valid),
  .src_idx    (src_idx),
  .dst_idx    (dst_idx),
  .write_zero (write_zero),
  .done       (done)
);

// File: tb/twin_pred_seq_test.sv
module twin_pred_seq_test;
  localparam int CRW = 272;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start;
  logic [6:0]     vl;
  logic [63:0]    src_pred, dst_pred;
  logic           src_inv, dst_inv, shared_pred, use_cr_pred;
  logic [CRW-1:0] cr_bits;
  logic           zero_en, src_scalar, dst_scalar;
  logic           elem_valid, write_zero, done;
  logic [5:0]     src_idx, dst_idx;

  int n_checks = 0;
  int n_fail   = 0;

  logic [12:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  twin_pred_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
    .src_pred(src_pred), .dst_pred(dst_pred),
    .src_inv(src_inv), .dst_inv(dst_inv),
    .shared_pred(shared_pred), .use_cr_pred(use_cr_pred),
    .cr_bits(cr_bits), .zero_en(zero_en),
    .src_scalar(src_scalar), .dst_scalar(dst_scalar),
    .elem_valid(elem_valid), .src_idx(src_idx), .dst_idx(dst_idx),
    .write_zero(write_zero), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && elem_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5", "unexpected pair {src,dst,wz}",
            longint'({src_idx, dst_idx, write_zero}), 0);
      end else begin
        logic [12:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({src_idx, dst_idx, write_zero} == e, t, "pair {src,dst,wz}",
            longint'({src_idx, dst_idx, write_zero}), longint'(e));
      end
    end
  end

  // reference walk of the requirements
  task automatic push_expected(input string tag);
    int          vle;
    logic [63:0] sm, dm;
    int          sp, dp, sc, dc;
    bit          sok, dok;
    vle = (int'(vl) > 64) ? 64 : int'(vl);
    for (int i = 0; i < 64; i++) begin
      logic rs, rd;
      rs = use_cr_pred ? cr_bits[(4 + i) * 4 + 1] : src_pred[i];
      rd = use_cr_pred ? cr_bits[(4 + i) * 4 + 1] : dst_pred[i];
      sm[i] = (rs ^ src_inv) && (i < vle);
      dm[i] = (rd ^ dst_inv) && (i < vle);
    end
    if (shared_pred) sm = dm;
    sp = 0;
    dp = 0;
    forever begin
      if (zero_en) begin
        dc  = dp;
        dok = (dp < vle);
      end else begin
        dc = dp;
        while (dc < vle && !dm[dc]) dc++;
        dok = (dc < vle);
      end
      if (src_scalar) begin
        sc  = 0;
        sok = 1'b1;
      end else if (shared_pred) begin
        sc  = dc;
        sok = dok;
      end else begin
        sc = sp;
        while (sc < vle && !sm[sc]) sc++;
        sok = (sc < vle);
      end
      if (!(sok && dok)) break;
      exp_q.push_back({sc[5:0], dc[5:0], zero_en && !dm[dc]});
      tag_q.push_back(tag);
      sp = sc + 1;
      dp = dst_scalar ? vle : dc + 1;
    end
  endtask

  task automatic defaults();
    vl = 7'd0; src_pred = '1; dst_pred = '1;
    src_inv = 0; dst_inv = 0; shared_pred = 0; use_cr_pred = 0;
    cr_bits = '0; zero_en = 0; src_scalar = 0; dst_scalar = 0;
  endtask

  task automatic run_case(input string tag);
    int waited;
    push_expected(tag);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(done == (vl == 7'd0), tag, "done one cycle after start", done, vl == 7'd0);
    chk(!elem_valid, "R2", "no pair on the start edge", elem_valid, 0);
    waited = 0;
    while (!done && waited < 300) begin
      @(negedge clk);
      waited++;
    end
    chk(done, tag, "done reached", done, 1);
    chk(exp_q.size() == 0, tag, "pairs still expected", exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    #4_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    defaults();
    repeat (3) @(negedge clk);
    chk(!elem_valid && !done && !write_zero, "R13", "outputs in reset",
        {elem_valid, done, write_zero}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!elem_valid && !done && !write_zero, "R13", "outputs after reset",
        {elem_valid, done, write_zero}, 0);

    // R1: empty length
    defaults(); vl = 7'd0;
    run_case("R1");

    // R2: done held until the next start
    repeat (3) @(negedge clk);
    chk(done && !elem_valid, "R2", "done held", {done, elem_valid}, 2);

    // R3: compress, source 0b101
    defaults(); vl = 7'd3; src_pred = 64'b101;
    run_case("R3");

    // R4: expand, destination 0b101
    defaults(); vl = 7'd3; dst_pred = 64'b101;
    run_case("R4");

    // R6: twin masks, destination inverted -> 0b010
    defaults(); vl = 7'd3; src_pred = 64'b101; dst_pred = 64'b101; dst_inv = 1;
    run_case("R6");

    // R6: source inversion, ~0b1010 keeps elements 0 and 2
    defaults(); vl = 7'd4; src_pred = 64'b1010; src_inv = 1;
    run_case("R6");

    // R5: destination runs out first
    defaults(); vl = 7'd4; dst_pred = 64'b0001;
    run_case("R5");

    // R7: zeroing, destination 0b01
    defaults(); vl = 7'd2; dst_pred = 64'b01; zero_en = 1;
    run_case("R7");

    // R7: zeroing with a sparse source
    defaults(); vl = 7'd4; src_pred = 64'b1101; dst_pred = 64'b0110; zero_en = 1;
    run_case("R7");

    // R8: shared mask 0b10
    defaults(); vl = 7'd2; dst_pred = 64'b10; src_pred = 64'b01; shared_pred = 1;
    run_case("R8");

    // R9: condition fields, field 4 EQ=1, field 5 EQ=0, inverted
    defaults(); vl = 7'd2; use_cr_pred = 1; shared_pred = 1; dst_inv = 1;
    cr_bits[4 * 4 + 1] = 1'b1;
    run_case("R9");

    // R9: condition fields without inversion, twin masks
    defaults(); vl = 7'd3; use_cr_pred = 1;
    cr_bits[5 * 4 + 1] = 1'b1; cr_bits[6 * 4 + 1] = 1'b1; cr_bits[4 * 4 + 2] = 1'b1;
    run_case("R9");

    // R10: scalar destination
    defaults(); vl = 7'd4; dst_scalar = 1;
    run_case("R10");

    // R11: scalar source, source mask ignored
    defaults(); vl = 7'd3; dst_pred = 64'b110; src_pred = 64'b0; src_scalar = 1;
    run_case("R11");

    // R12: bits above the length ignored
    defaults(); vl = 7'd2; src_pred = 64'hFFFF_FFFF_FFFF_FFFD;
    run_case("R12");

    // R12: length clamp, all ones up to element 63
    defaults(); vl = 7'd100;
    run_case("R12");

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule